// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Dispatcher

This block holds a two-word interrupt command. Writing the low word launches a command: the block assembles an interrupt message from the low-word fields and the destination byte held in the high word. It then works out which of `N_CPU` processors receive the message. Copies for other processors leave through a message port as a destination bitmask plus the message fields. A copy for the local processor goes out on a separate local-request strobe, towards the local interrupt arbiter.

The block is busy while any remote copy is still unacknowledged. It counts the remote targets of a launch and counts down on each returned response strobe. The delivery-status bit in the low word reads 1 until that count drains. While the bit is set, a new command write is discarded.

Top module: `ipi_cmd_dispatch`

## Requirements
- R1: After reset, `cmd_low` and `cmd_high` read 0, the delivery-status bit (bit 12 of `cmd_low`) is 0, and `msg_valid`, `local_req` and `cmd_error` are 0.
- R2: The low word carries the vector in bits 7:0, the delivery mode in bits 10:8, the destination mode in bit 11 (1 = logical), level in bit 14, trigger in bit 15 and the shorthand in bits 19:18. The high word keeps only its destination byte, bits 31:24, and reads 0 elsewhere. An accepted low write shows its message on the outputs in the cycle after the write edge, for exactly one cycle.
- R3: Shorthand 1 delivers only locally. Shorthand 2 delivers locally and to every other processor. Shorthand 3 delivers to every processor except the local one.
- R4: With shorthand 0 and physical mode, destination 0xFF delivers locally and to all other processors. A destination equal to `local_id` is delivered locally only. Any other destination below `N_CPU` selects that one processor, and a destination at or above `N_CPU` selects nobody.
- R5: With shorthand 0 and logical mode, bit i of the destination selects processor i. The bit of the local processor is delivered on the local path and never in the mask.
- R6: When a launch selects at least one remote processor, `msg_valid` pulses with that mask, and the delivery-status bit reads 1 from the next cycle. A launch with no remote target leaves the bit at 0.
- R7: A low-word write while the delivery-status bit is 1 leaves `cmd_low` unchanged and produces no message, no local request and no error.
- R8: Each `rsp_strobe` pulse retires one outstanding remote delivery. The status bit clears on the edge that retires the last one. A strobe while nothing is outstanding has no effect.
- R9: Delivery mode 1 (lowest priority) with shorthand 0 pulses `cmd_error` and sends nothing. It leaves the status bit at 0. With any other shorthand, that mode is dispatched normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_id | input | 8 | Identifier of the processor that owns this block |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the low word, 1 the high word |
| wr_data | input | 32 | Write data |
| cmd_low | output | 32 | Low word, delivery-status bit live in bit 12 |
| cmd_high | output | 32 | High word (destination byte only) |
| msg_valid | output | 1 | One-cycle pulse: a message leaves for remote processors |
| msg_dest_mask | output | N_CPU | Remote target bitmask |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Message delivery mode |
| msg_logical | output | 1 | Message destination mode |
| msg_level | output | 1 | Message level |
| msg_trigger | output | 1 | Message trigger |
| local_req | output | 1 | One-cycle pulse: deliver to the local processor |
| local_vector | output | 8 | Vector of the local delivery |
| local_mode | output | 3 | Delivery mode of the local delivery |
| local_trigger | output | 1 | Trigger of the local delivery |
| cmd_error | output | 1 | One-cycle pulse: rejected lowest-priority command |
| rsp_strobe | input | 1 | One pulse per response from a remote processor |

## Verification
Every result of a write is registered once, so message, local request and error pulses are due in the first cycle after the write edge. The delivery-status bit of a launch is also due from that cycle, and the bench drives at a falling edge and samples at the next falling edge. A response strobe changes the status bit one edge later, so the bench checks the bit after each strobe. It expects the bit to clear only after the strobe that matches the number of remote targets it predicted. Ignored writes are checked on the following cycle through the message outputs and the read-back of the low word.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  localparam int DEST_W    = 8;
  localparam int VEC_LSB   = 0;
  localparam int MODE_LSB  = 8;
  localparam int LOGIC_BIT = 11;
  localparam int BUSY_BIT  = 12;
  localparam int LEVEL_BIT = 14;
  localparam int TRIG_BIT  = 15;
  localparam int SH_LSB    = 18;
  localparam int DEST_LSB  = 24;

  localparam logic [2:0]        MODE_LOWEST = 3'b001;
  localparam logic [DEST_W-1:0] DEST_BCAST  = 8'hFF;

  typedef enum logic [1:0] {
    SH_FIELD    = 2'd0,
    SH_SELF     = 2'd1,
    SH_ALL_INCL = 2'd2,
    SH_ALL_EXCL = 2'd3
  } shorthand_e;

  typedef struct packed {
    logic [7:0] vector;
    logic [2:0] mode;
    logic       logical;
    logic       level;
    logic       trigger;
    shorthand_e sh;
  } cmd_fields_t;

  function automatic cmd_fields_t unpack_low(input logic [31:0] w);
    cmd_fields_t f;
    f.vector  = w[VEC_LSB +: 8];
    f.mode    = w[MODE_LSB +: 3];
    f.logical = w[LOGIC_BIT];
    f.level   = w[LEVEL_BIT];
    f.trigger = w[TRIG_BIT];
    f.sh      = shorthand_e'(w[SH_LSB +: 2]);
    return f;
  endfunction

  function automatic logic self_selected(input shorthand_e sh, input logic logical,
                                         input logic [DEST_W-1:0] dest,
                                         input logic [DEST_W-1:0] lid);
    logic r;
    case (sh)
      SH_SELF, SH_ALL_INCL: r = 1'b1;
      SH_ALL_EXCL:          r = 1'b0;
      default: begin
        if (logical) r = (lid < DEST_W) && dest[lid[2:0]];
        else         r = (dest == DEST_BCAST) || (dest == lid);
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ipi_target_decode.sv
module ipi_target_decode
  import ipi_pkg::*;
#(
  parameter int N_CPU = 8
) (
  input  shorthand_e          sh,
  input  logic                logical,
  input  logic [DEST_W-1:0]   dest,
  input  logic [DEST_W-1:0]   local_id,
  output logic [N_CPU-1:0]    remote_mask,
  output logic                local_hit
);

  assign local_hit = self_selected(sh, logical, dest, local_id);

  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    logic is_self;
    logic logical_pick;
    logic pick;

    assign is_self = (local_id == DEST_W'(i));

    if (i < DEST_W) begin : g_lbit
      assign logical_pick = dest[i];
    end else begin : g_nobit
      assign logical_pick = 1'b0;
    end

    always_comb begin
      case (sh)
        SH_SELF:     pick = 1'b0;
        SH_ALL_INCL: pick = 1'b1;
        SH_ALL_EXCL: pick = 1'b1;
        default:     pick = logical ? logical_pick
                                    : ((dest == DEST_BCAST) || (dest == DEST_W'(i)));
      endcase
    end

    assign remote_mask[i] = pick & ~is_self;
  end

endmodule

// File: rtl/ipi_pending_tracker.sv
module ipi_pending_tracker #(
  parameter int N_CPU = 8,
  localparam int CNT_W = $clog2(N_CPU + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [N_CPU-1:0] load_mask,
  input  logic             rsp,
  output logic             busy,
  output logic [CNT_W-1:0] outstanding
);

  function automatic logic [CNT_W-1:0] ones(input logic [N_CPU-1:0] m);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int k = 0; k < N_CPU; k++) c = c + CNT_W'(m[k]);
    return c;
  endfunction

  logic retire;
  assign retire = rsp && (outstanding != '0) && !load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outstanding <= '0;
      busy        <= 1'b0;
    end else if (load) begin
      outstanding <= ones(load_mask);
      busy        <= |load_mask;
    end else if (retire) begin
      outstanding <= outstanding - 1'b1;
      if (outstanding == CNT_W'(1)) busy <= 1'b0;
    end
  end

  AST_BUSY_TRACKS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (outstanding != '0)); // R8
  AST_RETIRE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> outstanding == $past(outstanding) - 1'b1); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp && outstanding == '0 && !load) |=> outstanding == '0); // R8

endmodule

// File: rtl/ipi_cmd_dispatch.sv
module ipi_cmd_dispatch
  import ipi_pkg::*;
#(
  parameter int N_CPU = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        local_id,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [31:0]       wr_data,
  output logic [31:0]       cmd_low,
  output logic [31:0]       cmd_high,
  output logic              msg_valid,
  output logic [N_CPU-1:0]  msg_dest_mask,
  output logic [7:0]        msg_vector,
  output logic [2:0]        msg_mode,
  output logic              msg_logical,
  output logic              msg_level,
  output logic              msg_trigger,
  output logic              local_req,
  output logic [7:0]        local_vector,
  output logic [2:0]        local_mode,
  output logic              local_trigger,
  output logic              cmd_error,
  input  logic              rsp_strobe
);

  localparam int CNT_W = $clog2(N_CPU + 1);
  localparam logic [31:0] HIGH_KEEP = 32'hFF00_0000;

  logic [31:0]       low_q;
  logic [31:0]       high_q;
  logic              busy;
  logic [CNT_W-1:0]  outstanding;
  cmd_fields_t       f;
  logic [DEST_W-1:0] dest;
  logic [N_CPU-1:0]  remote_mask;
  logic              local_hit;

  // named internal events
  logic low_wr, accept, lp_reject, fire;

  assign f         = unpack_low(wr_data);
  assign dest      = high_q[DEST_LSB +: DEST_W];
  assign low_wr    = wr_en && !wr_sel;
  assign accept    = low_wr && !busy;
  assign lp_reject = (f.mode == MODE_LOWEST) && (f.sh == SH_FIELD);
  assign fire      = accept && !lp_reject;

  ipi_target_decode #(.N_CPU(N_CPU)) u_decode (
    .sh          (f.sh),
    .logical     (f.logical),
    .dest        (dest),
    .local_id    (local_id),
    .remote_mask (remote_mask),
    .local_hit   (local_hit)
  );

  ipi_pending_tracker #(.N_CPU(N_CPU)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (fire),
    .load_mask   (remote_mask),
    .rsp         (rsp_strobe),
    .busy        (busy),
    .outstanding (outstanding)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_q  <= '0;
      high_q <= '0;
    end else begin
      if (accept) low_q <= wr_data & ~(32'd1 << BUSY_BIT);
      if (wr_en && wr_sel) high_q <= wr_data & HIGH_KEEP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid     <= 1'b0;
      msg_dest_mask <= '0;
      msg_vector    <= '0;
      msg_mode      <= '0;
      msg_logical   <= 1'b0;
      msg_level     <= 1'b0;
      msg_trigger   <= 1'b0;
      local_req     <= 1'b0;
      local_vector  <= '0;
      local_mode    <= '0;
      local_trigger <= 1'b0;
      cmd_error     <= 1'b0;
    end else begin
      msg_valid     <= fire && (|remote_mask);
      msg_dest_mask <= fire ? remote_mask : '0;
      local_req     <= fire && local_hit;
      cmd_error     <= accept && lp_reject;
      if (fire) begin
        msg_vector    <= f.vector;
        msg_mode      <= f.mode;
        msg_logical   <= f.logical;
        msg_level     <= f.level;
        msg_trigger   <= f.trigger;
        local_vector  <= f.vector;
        local_mode    <= f.mode;
        local_trigger <= f.trigger;
      end
    end
  end

  assign cmd_low  = low_q | ({31'd0, busy} << BUSY_BIT);
  assign cmd_high = high_q;

  AST_BUSY_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (low_wr && busy) |=> (!msg_valid && !local_req && !cmd_error && $stable(low_q))); // R7
  AST_SELF_NOT_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> ((msg_dest_mask >> local_id) & N_CPU'(1)) == '0); // R5
  AST_COUNT_ON_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (int'(outstanding) == $countones(msg_dest_mask))); // R6
  AST_BUSY_AFTER_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> cmd_low[BUSY_BIT]); // R6
  AST_ERROR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_error |-> (!msg_valid && !local_req && !cmd_low[BUSY_BIT])); // R9
  AST_MASK_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_dest_mask != '0)); // R2

endmodule

// File: tb/tb_ipi_cmd_dispatch.sv
`timescale 1ns/1ps
module tb_ipi_cmd_dispatch;
  localparam int N = 8;

  logic clk = 0, rst_n = 0;
  logic [7:0] local_id = 8'd2;
  logic wr_en = 0, wr_sel = 0, rsp_strobe = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] cmd_low, cmd_high;
  logic msg_valid, msg_logical, msg_level, msg_trigger, local_req, local_trigger, cmd_error;
  logic [N-1:0] msg_dest_mask;
  logic [7:0] msg_vector, local_vector;
  logic [2:0] msg_mode, local_mode;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ipi_cmd_dispatch #(.N_CPU(N)) dut (
    .clk(clk), .rst_n(rst_n), .local_id(local_id), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cmd_low(cmd_low), .cmd_high(cmd_high), .msg_valid(msg_valid),
    .msg_dest_mask(msg_dest_mask), .msg_vector(msg_vector), .msg_mode(msg_mode),
    .msg_logical(msg_logical), .msg_level(msg_level), .msg_trigger(msg_trigger),
    .local_req(local_req), .local_vector(local_vector), .local_mode(local_mode),
    .local_trigger(local_trigger), .cmd_error(cmd_error), .rsp_strobe(rsp_strobe));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench model of target selection
  function automatic logic [N-1:0] model_mask(input logic [1:0] sh, input logic lg,
                                              input logic [7:0] d, input logic [7:0] lid);
    logic [N-1:0] m = '0;
    for (int i = 0; i < N; i++) begin
      if (i == lid) continue;
      if (sh == 2'd2 || sh == 2'd3) m[i] = 1'b1;
      else if (sh == 2'd0) m[i] = lg ? d[i] : (d == 8'hFF || d == i);
    end
    return m;
  endfunction

  function automatic logic model_local(input logic [1:0] sh, input logic lg,
                                       input logic [7:0] d, input logic [7:0] lid);
    if (sh == 2'd1 || sh == 2'd2) return 1'b1;
    if (sh == 2'd3) return 1'b0;
    if (lg) return lid < 8 && d[lid];
    return d == 8'hFF || d == lid;
  endfunction

  function automatic int ones(input logic [N-1:0] m);
    int c = 0;
    for (int i = 0; i < N; i++) c += m[i];
    return c;
  endfunction

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse_rsp();
    @(negedge clk); rsp_strobe = 1;
    @(negedge clk); rsp_strobe = 0;
  endtask

  function automatic logic [31:0] mk_low(input logic [7:0] v, input logic [2:0] md,
                                         input logic lg, input logic lv, input logic tr,
                                         input logic [1:0] sh);
    return {12'd0, sh, 2'd0, tr, lv, 1'b0, 1'b0, lg, md, v};
  endfunction

  // full command with checks; retire responses afterwards
  task automatic run_cmd(input logic [7:0] d, input logic [31:0] lw, input bit poke_busy);
    logic [1:0] sh = lw[19:18];
    logic lg = lw[11];
    logic err = (lw[10:8] == 3'b001) && (sh == 2'd0);
    logic [N-1:0] em = err ? '0 : model_mask(sh, lg, d, local_id);
    logic el = err ? 1'b0 : model_local(sh, lg, d, local_id);
    int cnt = ones(em);
    wr(1'b1, {d, 24'h5A5A5A});
    check("R2 high keeps dest", cmd_high, {d, 24'd0});
    wr(1'b0, lw);
    check("R9 error pulse", cmd_error, err);
    check("R6 msg_valid", msg_valid, cnt != 0);
    check("R3/R4/R5 mask", msg_dest_mask, em);
    check("R3/R4/R5 local", local_req, el);
    if (cnt != 0) begin
      check("R2 vector", msg_vector, lw[7:0]);
      check("R2 fields", {msg_mode, msg_logical, msg_level, msg_trigger},
            {lw[10:8], lw[11], lw[14], lw[15]});
    end
    if (el) check("R2 local fields", {local_vector, local_mode, local_trigger},
                  {lw[7:0], lw[10:8], lw[15]});
    check("R6 busy bit", cmd_low[12], cnt != 0);
    check("R2 low readback", cmd_low & ~32'h1000, lw & ~32'h1000);
    @(negedge clk);
    check("R2 one-cycle pulse", {msg_valid, local_req, cmd_error}, 3'b000);
    if (cnt != 0 && poke_busy) begin
      wr(1'b0, mk_low(8'h77, 3'd0, 1'b0, 1'b0, 1'b0, 2'd2));
      check("R7 ignored no send", {msg_valid, local_req, cmd_error}, 3'b000);
      check("R7 low unchanged", cmd_low, (lw & ~32'h1000) | 32'h1000);
    end
    for (int k = 0; k < cnt; k++) begin
      pulse_rsp();
      check("R8 busy drain", cmd_low[12], k < cnt - 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset low", cmd_low, 32'd0);
    check("R1 reset high", cmd_high, 32'd0);
    check("R1 reset pulses", {msg_valid, local_req, cmd_error}, 3'b000);
    // R8: stray response while idle
    pulse_rsp();
    check("R8 idle rsp no effect", cmd_low[12], 1'b0);
    // directed corners
    run_cmd(8'h00, mk_low(8'h31, 3'd0, 1'b0, 1'b1, 1'b1, 2'd1), 0); // R3 self
    run_cmd(8'h00, mk_low(8'h32, 3'd0, 1'b0, 1'b0, 1'b1, 2'd2), 1); // R3 incl
    run_cmd(8'h00, mk_low(8'h33, 3'd4, 1'b0, 1'b1, 1'b0, 2'd3), 1); // R3 excl
    run_cmd(8'hFF, mk_low(8'h40, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0), 1); // R4 bcast
    run_cmd(8'd2,  mk_low(8'h41, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0), 0); // R4 self id
    run_cmd(8'd6,  mk_low(8'h42, 3'd2, 1'b0, 1'b0, 1'b0, 2'd0), 1); // R4 single
    run_cmd(8'd20, mk_low(8'h43, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0), 0); // R4 out of range
    run_cmd(8'hA5, mk_low(8'h50, 3'd0, 1'b1, 1'b0, 1'b1, 2'd0), 1); // R5 logical
    run_cmd(8'h04, mk_low(8'h51, 3'd0, 1'b1, 1'b0, 1'b0, 2'd0), 0); // R5 self only
    run_cmd(8'hFF, mk_low(8'h60, 3'd1, 1'b0, 1'b0, 1'b0, 2'd0), 0); // R9 reject
    run_cmd(8'h00, mk_low(8'h61, 3'd1, 1'b0, 1'b0, 1'b0, 2'd3), 0); // R9 allowed
    // constrained random
    for (int it = 0; it < 80; it++) begin
      logic [7:0] d;
      int pick = $urandom_range(0, 3);
      if (it == 40) begin @(negedge clk); local_id = 8'd5; end
      case (pick)
        0: d = 8'hFF;
        1: d = local_id;
        2: d = 8'($urandom_range(0, N - 1));
        default: d = 8'($urandom);
      endcase
      run_cmd(d, $urandom & 32'h000C_CFFF, ($urandom_range(0, 1) == 1));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule